// File: doc/BRIEF.md
# Floating-Point Stage Reservation Issue Controller

This block decides, cycle by cycle, whether a floating-point operation may enter a pipeline whose internal stages are shared between operation classes. Each class walks through a fixed sequence of stage resources. These are the unpack stage, the operand shifter, the mantissa adder, the rounder, the exception test, the two multiplier array stages and a condition-flag write port. Because the classes share some stages, the right to issue depends on where earlier operations will be in later cycles. A single busy flag per unit cannot capture that.

The controller keeps, for every resource, a vector of busy bits for the next few cycles. A request is held by the requester until it is granted. In each cycle the controller overlays the class's usage pattern on the occupancy vectors. If no resource would be claimed twice, it grants the request and merges the pattern into the occupancy. Otherwise it stalls, and the same request is judged again in the next cycle against the shifted occupancy. A per-class retire flag marks the cycle in which a granted operation is in its final stage.

Top module: `fp_reserve_issue`

## Requirements
- R1: After reset all retire flags are low, and the first request of any class is granted in the cycle it is presented.
- R2: In a cycle with `reqValid` high exactly one of `issueGrant` and `issueStall` is high, and with `reqValid` low both are low. The decision refers to the request in the same cycle.
- R3: The add/subtract class uses unpack; shifter and adder; adder and rounder; rounder and shifter in its four consecutive cycles. A second add/subtract is stalled one and two cycles after a grant and is granted three cycles after it.
- R4: The multiply class uses unpack; exception test and multiplier A; multiplier A three more times; multiplier B; multiplier B and adder; rounder in its eight cycles. A second multiply is stalled one to three cycles after a grant and is granted four cycles after it.
- R5: The negate/absolute-value class uses unpack then shifter. Such requests are granted in every consecutive cycle.
- R6: The compare class uses unpack, adder and rounder in turn, and holds the condition-flag port in its second and third cycles. A second compare is stalled one cycle after a grant and is granted two cycles after it.
- R7: With a multiply granted in cycle 0 and nothing else in flight, an add/subtract presented in cycle 4 or 5 is stalled. One presented in cycle 1, 2, 3, 6 or 7 is granted.
- R8: A stalled request reserves nothing. A request held after a stall is granted in the first cycle in which its pattern fits.
- R9: `reqOp` codes are 0 add/subtract, 1 multiply, 2 negate/absolute value, 3 compare. `retireMask` bit k is high in exactly the cycle that lies L-1 cycles after the grant of a class-k operation, with L being 4, 8, 2 and 3 for codes 0 to 3.
- R10: Operations of different classes whose final stages fall in the same cycle raise their retire bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An operation is requesting issue this cycle |
| reqOp | input | 2 | Operation class code of the request |
| issueGrant | output | 1 | Request accepted this cycle |
| issueStall | output | 1 | Request refused this cycle, to be presented again |
| retireMask | output | 4 | Per class, an operation is in its final stage this cycle |

## Verification
Grant and stall are combinational on the request, so they are due in the same cycle the request is presented. The bench drives each request at the falling edge and samples one nanosecond later, before the rising edge that commits the reservation. A retire bit is due L-1 cycles after its grant cycle. The bench's own calendar model records that due cycle at grant time and compares `retireMask` at the same sample point in every cycle. This makes a retire flag one cycle early or late a miscompare, as is a stall recorded in the wrong cycle of a sweep.

// File: rtl/fp_reserve_pkg.sv
package fp_reserve_pkg;

  localparam int NUM_RES = 8;
  localparam int NUM_OPS = 4;
  localparam int PAT_LEN = 8;
  localparam int OP_W    = $clog2(NUM_OPS);

  // resource indices
  localparam int RES_UNPK = 0;
  localparam int RES_SHFT = 1;
  localparam int RES_MADD = 2;
  localparam int RES_RND  = 3;
  localparam int RES_EXCT = 4;
  localparam int RES_MULA = 5;
  localparam int RES_MULB = 6;
  localparam int RES_FLAG = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADDSUB = 2'd0,
    OP_MUL    = 2'd1,
    OP_NEGABS = 2'd2,
    OP_CMP    = 2'd3
  } opClass_e;

  typedef struct packed {
    logic     issue;
    opClass_e op;
  } issueStrobe_t;

  // bit j set: resource res is used j cycles after the grant cycle
  function automatic logic [PAT_LEN-1:0] stageMask(opClass_e op, int res);
    logic [PAT_LEN-1:0] m;
    m = '0;
    case (op)
      OP_ADDSUB: begin
        case (res)
          RES_UNPK: m = 8'b0000_0001;
          RES_SHFT: m = 8'b0000_1010;
          RES_MADD: m = 8'b0000_0110;
          RES_RND:  m = 8'b0000_1100;
          default:  m = '0;
        endcase
      end
      OP_MUL: begin
        case (res)
          RES_UNPK: m = 8'b0000_0001;
          RES_EXCT: m = 8'b0000_0010;
          RES_MULA: m = 8'b0001_1110;
          RES_MULB: m = 8'b0110_0000;
          RES_MADD: m = 8'b0100_0000;
          RES_RND:  m = 8'b1000_0000;
          default:  m = '0;
        endcase
      end
      OP_NEGABS: begin
        case (res)
          RES_UNPK: m = 8'b0000_0001;
          RES_SHFT: m = 8'b0000_0010;
          default:  m = '0;
        endcase
      end
      default: begin
        case (res)
          RES_UNPK: m = 8'b0000_0001;
          RES_MADD: m = 8'b0000_0010;
          RES_RND:  m = 8'b0000_0100;
          RES_FLAG: m = 8'b0000_0110;
          default:  m = '0;
        endcase
      end
    endcase
    return m;
  endfunction

  function automatic int opLatency(opClass_e op);
    case (op)
      OP_ADDSUB: return 4;
      OP_MUL:    return 8;
      OP_NEGABS: return 2;
      default:   return 3;
    endcase
  endfunction

endpackage

// File: rtl/fp_reserve_ctrl.sv
module fp_reserve_ctrl
  import fp_reserve_pkg::*;
#(
  parameter int WINDOW = PAT_LEN
) (
  input  logic                 reqValid,
  input  logic [OP_W-1:0]      reqOp,
  input  logic [WINDOW-1:0]    occ [NUM_RES],
  output logic                 issueGrant,
  output logic                 issueStall,
  output issueStrobe_t         strobe
);

  opClass_e           opSel;
  logic [NUM_RES-1:0] hitVec;
  logic               collide;

  assign opSel = opClass_e'(reqOp);

  for (genvar r = 0; r < NUM_RES; r++) begin : g_probe
    assign hitVec[r] = |(occ[r] & WINDOW'(stageMask(opSel, r)));
  end

  assign collide    = |hitVec;
  assign issueGrant = reqValid && !collide;
  assign issueStall = reqValid && collide;

  always_comb begin
    strobe.issue = issueGrant;
    strobe.op    = opSel;
  end

endmodule

// File: rtl/fp_reserve_occupancy.sv
module fp_reserve_occupancy
  import fp_reserve_pkg::*;
#(
  parameter int WINDOW = PAT_LEN
) (
  input  logic              clk,
  input  logic              rstN,
  input  issueStrobe_t      strobe,
  output logic [WINDOW-1:0] occ [NUM_RES]
);

  for (genvar r = 0; r < NUM_RES; r++) begin : g_lane
    logic [WINDOW-1:0] claim;
    assign claim = strobe.issue ? WINDOW'(stageMask(strobe.op, r)) : '0;

    always_ff @(posedge clk) begin
      if (!rstN) occ[r] <= '0;
      else       occ[r] <= (occ[r] | claim) >> 1;
    end
  end

endmodule

// File: rtl/fp_reserve_retire.sv
module fp_reserve_retire
  import fp_reserve_pkg::*;
#(
  parameter int WINDOW = PAT_LEN
) (
  input  logic               clk,
  input  logic               rstN,
  input  issueStrobe_t       strobe,
  output logic [NUM_OPS-1:0] retireMask
);

  for (genvar c = 0; c < NUM_OPS; c++) begin : g_class
    localparam int                LAT = opLatency(opClass_e'(c));
    localparam logic [WINDOW-1:0] ARM = WINDOW'(1) << (LAT - 1);

    logic [WINDOW-1:0] pend;
    logic              armNow;

    assign armNow = strobe.issue && (strobe.op == opClass_e'(c));

    always_ff @(posedge clk) begin
      if (!rstN) pend <= '0;
      else       pend <= (pend | (armNow ? ARM : '0)) >> 1;
    end

    assign retireMask[c] = pend[0];
  end

endmodule

// File: rtl/fp_reserve_issue.sv
module fp_reserve_issue
  import fp_reserve_pkg::*;
#(
  parameter int WINDOW = PAT_LEN
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [OP_W-1:0]    reqOp,
  output logic               issueGrant,
  output logic               issueStall,
  output logic [NUM_OPS-1:0] retireMask
);

  if (WINDOW < PAT_LEN) begin : g_bad_window
    $error("WINDOW must cover the longest usage pattern");
  end

  issueStrobe_t      strobe;
  logic [WINDOW-1:0] occ [NUM_RES];

  fp_reserve_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .occ        (occ),
    .issueGrant (issueGrant),
    .issueStall (issueStall),
    .strobe     (strobe)
  );

  fp_reserve_occupancy #(.WINDOW(WINDOW)) u_occ (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .occ    (occ)
  );

  fp_reserve_retire #(.WINDOW(WINDOW)) u_ret (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .retireMask (retireMask)
  );

endmodule

// File: rtl/fp_reserve_issue_chk.sv
module fp_reserve_issue_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqOp,
  input logic       issueGrant,
  input logic       issueStall,
  input logic [3:0] retireMask
);

  logic [3:0] cyc;
  logic [3:0] sinceAdd, sinceMul, sinceCmp;
  logic       gAdd, gMul, gNeg, gCmp;

  assign gAdd = issueGrant && (reqOp == 2'd0);
  assign gMul = issueGrant && (reqOp == 2'd1);
  assign gNeg = issueGrant && (reqOp == 2'd2);
  assign gCmp = issueGrant && (reqOp == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyc      <= '0;
      sinceAdd <= 4'd15;
      sinceMul <= 4'd15;
      sinceCmp <= 4'd15;
    end else begin
      cyc      <= (cyc == 4'd15) ? cyc : cyc + 4'd1;
      sinceAdd <= gAdd ? 4'd1 : ((sinceAdd == 4'd15) ? sinceAdd : sinceAdd + 4'd1);
      sinceMul <= gMul ? 4'd1 : ((sinceMul == 4'd15) ? sinceMul : sinceMul + 4'd1);
      sinceCmp <= gCmp ? 4'd1 : ((sinceCmp == 4'd15) ? sinceCmp : sinceCmp + 4'd1);
    end
  end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(issueGrant && issueStall));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!issueGrant && !issueStall));

  a_r3_add_spacing: assert property (@(posedge clk) disable iff (!rstN)
    gAdd |-> (sinceAdd >= 4'd3));

  a_r4_mul_spacing: assert property (@(posedge clk) disable iff (!rstN)
    gMul |-> (sinceMul >= 4'd4));

  a_r6_cmp_spacing: assert property (@(posedge clk) disable iff (!rstN)
    gCmp |-> (sinceCmp >= 4'd2));

  a_r7_add_after_mul: assert property (@(posedge clk) disable iff (!rstN)
    (gAdd && cyc >= 4'd5) |-> !($past(gMul, 4) || $past(gMul, 5)));

  a_r9_add_retire: assert property (@(posedge clk) disable iff (!rstN)
    retireMask[0] |-> (cyc >= 4'd3 && $past(gAdd, 3)));

  a_r9_mul_retire: assert property (@(posedge clk) disable iff (!rstN)
    retireMask[1] |-> (cyc >= 4'd7 && $past(gMul, 7)));

  a_r9_neg_retire: assert property (@(posedge clk) disable iff (!rstN)
    retireMask[2] |-> (cyc >= 4'd1 && $past(gNeg, 1)));

  a_r9_cmp_retire: assert property (@(posedge clk) disable iff (!rstN)
    retireMask[3] |-> (cyc >= 4'd2 && $past(gCmp, 2)));

endmodule

bind fp_reserve_issue fp_reserve_issue_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqOp      (reqOp),
  .issueGrant (issueGrant),
  .issueStall (issueStall),
  .retireMask (retireMask)
);

// File: tb/sim_fp_reserve_issue.sv
`timescale 1ns/1ps
module sim_fp_reserve_issue;

  localparam int PERIOD = 4;
  localparam int CAL    = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid;
  logic [1:0] reqOp;
  logic       issueGrant;
  logic       issueStall;
  logic [3:0] retireMask;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [7:0] cal    [CAL];
  logic [3:0] retExp [CAL];
  int         cyc = 0;

  always #(PERIOD/2) clk = ~clk;

  fp_reserve_issue u0 (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .issueGrant (issueGrant),
    .issueStall (issueStall),
    .retireMask (retireMask)
  );

  // per-stage resource set: bit0 unpack, 1 shift, 2 adder, 3 round,
  // 4 exception test, 5 mult A, 6 mult B, 7 flag port
  function automatic logic [7:0] benchUse(logic [1:0] op, int stage);
    case (op)
      2'd0: case (stage) 0: return 8'h01; 1: return 8'h06; 2: return 8'h0C;
                         3: return 8'h0A; default: return 8'h00; endcase
      2'd1: case (stage) 0: return 8'h01; 1: return 8'h30; 2, 3, 4: return 8'h20;
                         5: return 8'h40; 6: return 8'h44; 7: return 8'h08;
                         default: return 8'h00; endcase
      2'd2: case (stage) 0: return 8'h01; 1: return 8'h02; default: return 8'h00; endcase
      default: case (stage) 0: return 8'h01; 1: return 8'h84; 2: return 8'h88;
                            default: return 8'h00; endcase
    endcase
  endfunction

  function automatic int benchLat(logic [1:0] op);
    case (op) 2'd0: return 4; 2'd1: return 8; 2'd2: return 2; default: return 3; endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op,
                      output logic gotGrant, output logic [3:0] gotRet);
    bit   clash;
    bit   expG;
    int   slot;
    @(negedge clk);
    reqValid = v;
    reqOp    = op;
    #1;
    slot  = cyc % CAL;
    clash = 1'b0;
    if (v)
      for (int j = 0; j < benchLat(op); j++)
        if ((cal[(cyc + j) % CAL] & benchUse(op, j)) != 8'h00) clash = 1'b1;
    expG = v && !clash;
    check(issueGrant == expG, "R2 grant", int'(issueGrant), int'(expG));
    check(issueStall == (v && clash), "R2 stall", int'(issueStall), int'(v && clash));
    check(retireMask == retExp[slot], "R9 retire", int'(retireMask), int'(retExp[slot]));
    if (expG) begin
      for (int j = 0; j < benchLat(op); j++)
        cal[(cyc + j) % CAL] |= benchUse(op, j);
      retExp[(cyc + benchLat(op) - 1) % CAL][op] = 1'b1;
    end
    gotGrant = issueGrant;
    gotRet   = retireMask;
    cal[slot]    = 8'h00;
    retExp[slot] = 4'h0;
    cyc++;
  endtask

  task automatic idle(input int n);
    logic g; logic [3:0] r;
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, g, r);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL R2 watchdog actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic g;
    logic [3:0] r;
    logic [1:0] curOp;
    logic curV;
    void'($urandom(32'd20240611));
    for (int i = 0; i < CAL; i++) begin cal[i] = 8'h00; retExp[i] = 4'h0; end
    rstN = 1'b0; reqValid = 1'b0; reqOp = 2'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    check(retireMask == 4'h0, "R1 reset retire", int'(retireMask), 0);
    check(!issueGrant && !issueStall, "R1 reset idle", int'(issueGrant), 0);
    rstN = 1'b1;

    // R1: first request after reset granted
    step(1'b1, 2'd1, g, r);
    check(g == 1'b1, "R1 first grant", int'(g), 1);
    idle(10);

    // R3: add spacing
    step(1'b1, 2'd0, g, r);
    for (int k = 1; k <= 3; k++) begin
      step(1'b1, 2'd0, g, r);
      check(g == (k == 3), "R3 add held", int'(g), int'(k == 3));
    end
    idle(10);

    // R4: multiply spacing
    step(1'b1, 2'd1, g, r);
    for (int k = 1; k <= 4; k++) begin
      step(1'b1, 2'd1, g, r);
      check(g == (k == 4), "R4 mul held", int'(g), int'(k == 4));
    end
    idle(12);

    // R5: negate every cycle
    for (int k = 0; k < 5; k++) begin
      step(1'b1, 2'd2, g, r);
      check(g == 1'b1, "R5 neg stream", int'(g), 1);
    end
    idle(6);

    // R6: compare spacing
    step(1'b1, 2'd3, g, r);
    step(1'b1, 2'd3, g, r);
    check(g == 1'b0, "R6 cmp stall", int'(g), 0);
    step(1'b1, 2'd3, g, r);
    check(g == 1'b1, "R6 cmp grant", int'(g), 1);
    idle(8);

    // R7: add offset sweep after a multiply
    for (int d = 1; d <= 7; d++) begin
      step(1'b1, 2'd1, g, r);
      idle(d - 1);
      step(1'b1, 2'd0, g, r);
      check(g == !(d == 4 || d == 5), "R7 add after mul", int'(g), int'(!(d == 4 || d == 5)));
      idle(12);
    end

    // R8: held add after a multiply, then a negate that a leaked reservation would block
    step(1'b1, 2'd1, g, r);
    idle(3);
    step(1'b1, 2'd0, g, r);
    check(g == 1'b0, "R8 stall at 4", int'(g), 0);
    step(1'b1, 2'd0, g, r);
    check(g == 1'b0, "R8 stall at 5", int'(g), 0);
    step(1'b1, 2'd0, g, r);
    check(g == 1'b1, "R8 grant at 6", int'(g), 1);
    step(1'b1, 2'd2, g, r);
    check(g == 1'b1, "R8 neg at 7", int'(g), 1);
    idle(12);

    // R9: isolated multiply retires 7 cycles after grant
    step(1'b1, 2'd1, g, r);
    for (int k = 1; k <= 8; k++) begin
      step(1'b0, 2'd0, g, r);
      check(r[1] == (k == 7), "R9 mul retire", int'(r[1]), int'(k == 7));
    end
    idle(4);

    // R10: compare then negate retire together
    step(1'b1, 2'd3, g, r);
    step(1'b1, 2'd2, g, r);
    check(g == 1'b1, "R10 neg granted", int'(g), 1);
    step(1'b0, 2'd0, g, r);
    check(r == 4'b1100, "R10 joint retire", int'(r), 12);
    idle(8);

    // random mix, request held while stalled
    curV = 1'b0; curOp = 2'd0;
    for (int i = 0; i < 3000; i++) begin
      if (!curV || g) begin
        curV  = ($urandom % 10) < 6;
        curOp = 2'($urandom % 4);
      end
      step(curV, curOp, g, r);
      if (!curV) g = 1'b1;
    end
    idle(10);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule